// File: doc/BRIEF.md
# Sparse Ternary Position Picker

This block fills a ternary coefficient array of length N so that exactly DR entries hold +1 and exactly DR entries hold -1, with every other entry zero. The positions come from a stream of pseudo-random bits supplied by an external generator. Every CW-bit slice of that stream is a candidate position. The block reduces the candidate modulo N by subtracting N once per cycle. It then places the coefficient there, unless that position is already taken; a taken position is thrown away and the next slice is tried.

Bits arrive as WW-bit words over a valid/ready handshake. The block takes words early, while it is still reducing the current candidate, whenever it holds fewer than CW bits. When it needs a candidate and the bits it holds are too few, it raises a refill request and waits. A start pulse clears the array and the held bits and begins a new run. When the last position is placed, done goes high and stays high, and the array can be read one position at a time.

Run time depends on the data, because it varies with the number of rejected candidates and with the number of subtractions each candidate needs.

Top module: `bpoly_idx_sel`

## Requirements
- R1: After reset, done, in_ready and refill_req are 0 and every position reads as zero (code 2'b00).
- R2: A start pulse while idle or done clears the array, the occupancy map and all held bits, and done is 0 from the next cycle. A start pulse during a run has no effect on the result or the run time.
- R3: Each candidate is the next CW bits of the stream. Words are used in the order they were accepted, and each word is used most significant bit first.
- R4: A candidate of value N or more loses N in each cycle, one subtraction per cycle, until it is below N.
- R5: A reduced candidate that names a position already nonzero is discarded, and the array and map are unchanged. The next CW bits give the next candidate.
- R6: The first DR accepted positions get +1 (code 2'b01) and the next DR get -1 (code 2'b11). Untouched positions stay 2'b00.
- R7: After 2*DR placements done rises and stays high until the next start. At that point exactly 2*DR positions are occupied.
- R8: in_ready is 1 while a run is in progress and fewer than CW bits are held; a word is taken on in_valid && in_ready. refill_req is 1 only while the block waits for a candidate it cannot form, and the block makes no progress while it waits.
- R9: Each candidate costs one fetch cycle, one cycle per subtraction and one decision cycle. With WW = 2*CW and words always offered, done is first high 1 + sum(q_i + 2) cycles after the start edge, where q_i = floor(v_i / N). In that case the number of words taken is floor(K/2) + 1 for K candidates.
- R10: rd_coef shows the code of position rd_addr combinationally. An address of N or more reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new run (honoured when idle or done) |
| in_valid | input | 1 | A random word is offered |
| in_word | input | WW | Random bits, most significant first |
| in_ready | output | 1 | Word is taken this cycle when in_valid is also high |
| refill_req | output | 1 | The block is stalled waiting for bits |
| done | output | 1 | All 2*DR positions placed |
| rd_addr | input | clog2(N) | Read position |
| rd_coef | output | 2 | Code at rd_addr: 00 zero, 01 +1, 11 -1 |

## Verification
A word load and a subtraction or decision step can fall in the same cycle. This happens because the buffer takes a new word while the previous candidate is still being reduced. The bench provokes it by offering words in every cycle, with WW = 2*CW, so each word that empties the buffer is followed at once by a load during the next reduction. It judges the overlap by requiring the exact cycle count 1 + sum(q_i + 2): any stall caused by a lost overlap adds cycles. It also requires the exact number of words taken and the full coefficient array from a model the bench computes itself. Runs with gaps in in_valid make refill_req show, and the results must still match.

// File: rtl/bpis_pkg.sv
package bpis_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REDUCE = 2'd2,
        ST_DONE   = 2'd3
    } bpis_state_e;

    localparam logic [1:0] COEF_ZERO = 2'b00;
    localparam logic [1:0] COEF_POS  = 2'b01;
    localparam logic [1:0] COEF_NEG  = 2'b11;

    function automatic int bpis_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bpis_bitbuf.sv
module bpis_bitbuf #(
    parameter int CW = 4,
    parameter int WW = 8,
    localparam int BW   = WW + CW - 1,
    localparam int CNTW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          in_valid,
    input  logic [WW-1:0] in_word,
    output logic          in_ready,
    input  logic          take,
    output logic          avail,
    output logic [CW-1:0] chunk
);

    typedef struct packed {
        logic [BW-1:0]   bits;
        logic [CNTW-1:0] cnt;
    } buf_t;

    buf_t st_d, st_q;
    logic [BW-1:0] ext;

    always_comb begin
        ext = '0;
        ext[BW-1 -: WW] = in_word;
        in_ready = run && (st_q.cnt < CNTW'(CW));
        avail    = (st_q.cnt >= CNTW'(CW));
        chunk    = st_q.bits[BW-1 -: CW];
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (take && avail) begin
            st_d.bits = st_q.bits << CW;
            st_d.cnt  = st_q.cnt - CNTW'(CW);
        end else if (in_valid && in_ready) begin
            st_d.bits = st_q.bits | (ext >> st_q.cnt);
            st_d.cnt  = st_q.cnt + CNTW'(WW);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bpis_modsub.sv
module bpis_modsub #(
    parameter int N  = 7,
    parameter int VW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] ld_val,
    input  logic          step,
    output logic [VW-1:0] val,
    output logic          ge
);

    typedef struct packed {
        logic [VW-1:0] val;
    } red_t;

    red_t st_d, st_q;

    always_comb begin
        ge   = (st_q.val >= VW'(N));
        val  = st_q.val;
        st_d = st_q;
        if (load)
            st_d.val = ld_val;
        else if (step && ge)
            st_d.val = st_q.val - VW'(N);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bpis_coef_store.sv
module bpis_coef_store
    import bpis_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic          wr_neg,
    input  logic [AW-1:0] idx,
    output logic          hit,
    input  logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_coef,
    output logic [N-1:0]  occ
);

    typedef struct packed {
        logic [N-1:0]      occ;
        logic [N-1:0][1:0] coef;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        hit     = 1'b0;
        rd_coef = COEF_ZERO;
        occ     = st_q.occ;
        st_d    = st_q;
        for (int i = 0; i < N; i++) begin
            if (idx == AW'(i))     hit     = st_q.occ[i];
            if (rd_addr == AW'(i)) rd_coef = st_q.coef[i];
        end
        if (clear) begin
            st_d = '0;
        end else if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (idx == AW'(i)) begin
                    st_d.occ[i]  = 1'b1;
                    st_d.coef[i] = wr_neg ? COEF_NEG : COEF_POS;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bpoly_idx_sel.sv
module bpoly_idx_sel
    import bpis_pkg::*;
#(
    parameter int N  = 7,
    parameter int CW = 4,
    parameter int WW = 8,
    parameter int DR = 2,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [WW-1:0] in_word,
    output logic          in_ready,
    output logic          refill_req,
    output logic          done,
    input  logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_coef
);

    localparam int VW = bpis_max(CW, AW) + 1;
    localparam int PW = $clog2(2 * DR + 1);

    typedef struct packed {
        bpis_state_e   state;
        logic [PW-1:0] placed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          clear, take, ld, step, wr_en, wr_neg, busy;
    logic          avail, cand_ge, occ_hit;
    logic [CW-1:0] chunk;
    logic [VW-1:0] cand_val;
    logic [N-1:0]  occ_vec;

    bpis_bitbuf #(.CW(CW), .WW(WW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(clear), .run(busy),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .take(take), .avail(avail), .chunk(chunk)
    );

    bpis_modsub #(.N(N), .VW(VW)) u_red (
        .clk(clk), .rst_n(rst_n), .load(ld), .ld_val(VW'(chunk)),
        .step(step), .val(cand_val), .ge(cand_ge)
    );

    bpis_coef_store #(.N(N), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
        .wr_neg(wr_neg), .idx(cand_val[AW-1:0]), .hit(occ_hit),
        .rd_addr(rd_addr), .rd_coef(rd_coef), .occ(occ_vec)
    );

    always_comb begin
        ctl_d  = ctl_q;
        clear  = 1'b0;
        take   = 1'b0;
        ld     = 1'b0;
        step   = 1'b0;
        wr_en  = 1'b0;
        wr_neg = (ctl_q.placed >= PW'(DR));
        busy   = (ctl_q.state == ST_FETCH) || (ctl_q.state == ST_REDUCE);
        done   = (ctl_q.state == ST_DONE);
        refill_req = (ctl_q.state == ST_FETCH) && !avail;
        unique case (ctl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    clear        = 1'b1;
                    ctl_d.state  = ST_FETCH;
                    ctl_d.placed = '0;
                end
            end
            ST_FETCH: begin
                if (avail) begin
                    take        = 1'b1;
                    ld          = 1'b1;
                    ctl_d.state = ST_REDUCE;
                end
            end
            ST_REDUCE: begin
                if (cand_ge) begin
                    step = 1'b1;
                end else if (occ_hit) begin
                    ctl_d.state = ST_FETCH;
                end else begin
                    wr_en        = 1'b1;
                    ctl_d.placed = ctl_q.placed + PW'(1);
                    ctl_d.state  = (ctl_q.placed == PW'(2 * DR - 1)) ? ST_DONE : ST_FETCH;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, placed: '0};
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/bpis_checker.sv
module bpis_checker
    import bpis_pkg::*;
#(
    parameter int N  = 7,
    parameter int DR = 2,
    parameter int VW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          in_ready,
    input logic          refill_req,
    input bpis_state_e   st,
    input logic [VW-1:0] val,
    input logic          ge,
    input logic [N-1:0]  occ
);

    logic busy;
    assign busy = (st == ST_FETCH) || (st == ST_REDUCE);

    // R4: one subtraction of N per cycle
    a_r4_one_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REDUCE && ge) |=> (val == $past(val) - VW'(N)));

    // R2: start when not running clears the map and done
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (occ == '0 && !done));

    // R2: start in the middle of a reduction changes nothing
    a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st == ST_REDUCE && ge) |=> (st == ST_REDUCE));

    // R5: occupied positions never drop out during a run
    a_r5_occ_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((occ & $past(occ)) == $past(occ)));

    // R7: done holds until a new start
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R7: exact number of occupied positions when finished
    a_r7_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(occ) == 2 * DR));

    // R8: a stall always comes with a request for words
    a_r8_refill_ready: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> in_ready);

endmodule

bind bpoly_idx_sel bpis_checker #(.N(N), .DR(DR), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .in_ready(in_ready), .refill_req(refill_req), .st(ctl_q.state),
    .val(cand_val), .ge(cand_ge), .occ(occ_vec)
);

// File: tb/bpoly_idx_sel_test.sv
module bpoly_idx_sel_test;

    localparam int N  = 7;
    localparam int CW = 4;
    localparam int WW = 8;
    localparam int DR = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [WW-1:0] in_word = '0;
    logic          in_ready, refill_req, done;
    logic [AW-1:0] rd_addr = '0;
    logic [1:0]    rd_coef;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] wbuf [0:63];
    logic [1:0] exp_coef [0:N-1];
    int exp_lat, exp_k;

    always #10 clk = ~clk;

    bpoly_idx_sel #(.N(N), .CW(CW), .WW(WW), .DR(DR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_word(in_word), .in_ready(in_ready), .refill_req(refill_req),
        .done(done), .rd_addr(rd_addr), .rd_coef(rd_coef)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_model();
        int placed;
        logic [N-1:0] occ;
        placed = 0;
        occ = '0;
        exp_lat = 1;
        exp_k = 0;
        for (int i = 0; i < N; i++) exp_coef[i] = 2'b00;
        for (int c = 0; c < 128; c++) begin
            int v, p;
            if (placed == 2 * DR) break;
            v = (c % 2 == 0) ? int'(wbuf[c / 2][7:4]) : int'(wbuf[c / 2][3:0]);
            p = v % N;
            exp_lat += v / N + 2;
            exp_k++;
            if (!occ[p]) begin
                occ[p] = 1'b1;
                exp_coef[p] = (placed < DR) ? 2'b01 : 2'b11;
                placed++;
            end
        end
    endtask

    task automatic fill_stream(input int seed);
        logic [31:0] x;
        x = 32'(seed) * 32'd2654435761 + 32'd7;
        for (int i = 0; i < 64; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            wbuf[i] = x[23:16];
        end
    endtask

    // mode 0: words always offered; 1: gaps in in_valid; 2: stray start mid-run
    task automatic run_case(input int mode, output int lat, output int words, output int saw_req);
        int widx, cyc;
        logic hs;
        build_model();
        widx = 0; cyc = 0; words = 0; saw_req = 0; lat = -1;
        @(negedge clk);
        start = 1'b1;
        in_valid = 1'b1;
        in_word = wbuf[0];
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 done low after start", int'(done), 0);
        for (int it = 0; it < 2000; it++) begin
            hs = in_valid && in_ready;
            if (refill_req) saw_req = 1;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (hs) begin
                words++;
                if (widx < 63) widx++;
            end
            in_word  = wbuf[widx];
            in_valid = (mode == 1) ? (cyc % 3 == 0) : 1'b1;
            start    = (mode == 2) && (cyc == 3);
            if (done) begin
                lat = cyc;
                break;
            end
        end
        start = 1'b0;
        in_valid = 1'b0;
        check("R7 done reached", int'(done), 1);
        for (int i = 0; i < N; i++) begin
            rd_addr = AW'(i);
            #1;
            check($sformatf("R3 R6 coef at %0d", i), int'(rd_coef), int'(exp_coef[i]));
        end
        rd_addr = AW'(7);
        #1;
        check("R10 out of range read", int'(rd_coef), 0);
        repeat (3) @(negedge clk);
        check("R7 done stays high", int'(done), 1);
    endtask

    initial begin
        int lat, words, req;
        #5;
        check("R1 done after reset", int'(done), 0);
        check("R1 in_ready after reset", int'(in_ready), 0);
        check("R1 refill_req after reset", int'(refill_req), 0);
        for (int i = 0; i < N; i++) begin
            rd_addr = AW'(i);
            #1;
            check("R1 coef zero after reset", int'(rd_coef), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed stream: large values, repeats, rejections
        wbuf[0] = 8'hE0; wbuf[1] = 8'hF8; wbuf[2] = 8'h7E; wbuf[3] = 8'h13;
        wbuf[4] = 8'h22; wbuf[5] = 8'hC5; wbuf[6] = 8'h46;
        for (int i = 7; i < 64; i++) wbuf[i] = 8'(i * 37 + 5);
        run_case(0, lat, words, req);
        check("R4 R5 R9 directed latency", lat, exp_lat);
        check("R8 R9 directed words taken", words, exp_k / 2 + 1);

        // sweep with words always offered
        for (int s = 1; s <= 40; s++) begin
            fill_stream(s);
            run_case(0, lat, words, req);
            check("R4 R9 sweep latency", lat, exp_lat);
            check("R8 R9 sweep words taken", words, exp_k / 2 + 1);
        end

        // gaps in the word stream
        for (int s = 100; s < 108; s++) begin
            fill_stream(s);
            run_case(1, lat, words, req);
            check("R8 refill request seen", req, 1);
            check("R8 stall only lengthens run", int'(lat >= exp_lat), 1);
        end

        // stray start during a run
        for (int s = 200; s < 206; s++) begin
            fill_stream(s);
            run_case(2, lat, words, req);
            check("R2 stray start latency", lat, exp_lat);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule